// File: doc/BRIEF.md
# Transmit buffer chain walker

This block turns a chain of transmit buffer descriptors into a byte stream for one outgoing frame. Each descriptor carries an ownership flag, an end-of-frame flag and a 12-bit length held as a negative number. The walker reads a descriptor and loads its length into a counter. It then issues one byte request toward memory for each byte of the buffer and moves on. It stops at the buffer flagged as the end of the frame, or it follows the chain into the next descriptor.

The walker watches the transmit FIFO level while the frame is in flight. Three conditions are errors: the FIFO runs dry in the middle of a buffer, the next descriptor is not owned, or the FIFO runs dry while the next descriptor is still being fetched. On any of these the walker writes error flags back to the current descriptor and turns its transmitter-on output off. No further frame is started until the host turns the transmitter on again. Ring addressing is left to the surrounding logic: the walker only selects the current or the next entry and pulses an advance strobe.

Top module: `txw_chain_walker`

## Requirements
- R1: After a synchronous reset, txon, dsc_rd, dsc_adv, dsc_wr and byte_req are all low.
- R2: A txon_set pulse raises txon. A tx_poll pulse starts a descriptor read (dsc_rd high, dsc_sel low) only while txon is high, and is ignored otherwise, including after an error has cleared txon.
- R3: A length field c (12 bits, two's complement of the byte count) produces exactly 4096 - c accepted byte transfers (byte_req and byte_ack both high). A field of 0xFFF gives a single byte.
- R4: byte_req is never high while fifo_full is high or while a descriptor read is pending. Requests resume when fifo_full falls.
- R5: When a buffer without the end-of-frame flag (dsc_eop low) has its last byte accepted, dsc_rd is high with dsc_sel high in the very next cycle. An owned next entry (dsc_own high) is followed by a one-cycle dsc_adv pulse and streaming of its bytes.
- R6: If the first descriptor of a frame is not owned, the walker returns to idle with no byte request, no write-back and no change to txon.
- R7: If the next descriptor in a chain is not owned, the walker performs one write-back with dsc_wflags = 2'b11 and clears txon. The write-back flags are bit 1 for buffer error and bit 0 for underflow.
- R8: If fifo_empty is high in a cycle where the next-descriptor read is pending without dsc_ack, the walker writes back 2'b11, clears txon and drops dsc_rd.
- R9: After the first byte of a frame, fifo_empty in a streaming cycle without a byte transfer truncates the frame. The walker writes back 2'b01, clears txon and issues no further byte request.
- R10: fifo_empty before the first byte of a frame, or after the last byte of the end-of-frame buffer, causes no write-back.
- R11: After the last byte of the end-of-frame buffer the walker pulses dsc_adv once and returns to idle with txon unchanged.
- R12: Every write-back has the underflow bit set, so a buffer error is never reported without an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txon_set | input | 1 | Host pulse that turns the transmitter on |
| tx_poll | input | 1 | Pulse asking the walker to start a frame |
| txon | output | 1 | Transmitter-on state |
| dsc_rd | output | 1 | Descriptor read request, held until dsc_ack |
| dsc_sel | output | 1 | Entry selected for the read: 0 current, 1 next |
| dsc_ack | input | 1 | Descriptor read data valid |
| dsc_own | input | 1 | Ownership flag of the read entry |
| dsc_eop | input | 1 | End-of-frame flag of the read entry |
| dsc_cnt | input | CNT_W | Negative byte count of the read entry |
| dsc_adv | output | 1 | Pulse: the next entry becomes current |
| dsc_wr | output | 1 | Pulse: set the error flags of the current entry |
| dsc_wflags | output | 2 | Flags to set: bit 1 buffer error, bit 0 underflow |
| byte_req | output | 1 | Byte request toward memory |
| byte_ack | input | 1 | Byte accepted into the FIFO this cycle |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_full | input | 1 | Transmit FIFO is full |

## Verification
The byte path is tried with single buffers of one and several bytes and with chains of two and three buffers of mixed lengths. These cases separate an off-by-one in the negative-count wrap from a chain that skips or repeats an entry. Ownership patterns that end the chain at the first or at a later entry separate a silent abort from a buffer error. FIFO patterns separate a harmless empty FIFO at the frame edges from a mid-buffer underflow and from a late next-descriptor status. Back-pressure from a full FIFO shows that no byte is requested early.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef enum logic [1:0] {
    TXW_IDLE   = 2'd0,
    TXW_FETCH  = 2'd1,
    TXW_STREAM = 2'd2
  } txw_state_e;

  typedef struct packed {
    logic buff;
    logic uflo;
  } txw_flags_t;

endpackage

// File: rtl/txw_byte_cnt.sv
// Negative byte counter: loaded with -N, counts up per byte, last when all ones.
module txw_byte_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             inc,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The byte taken while the count is all ones wraps it to zero.
  assign last = &cnt_q;

endmodule

// File: rtl/txw_err_wb.sv
// Registers the error write-back; a buffer error always carries an underflow.
module txw_err_wb
  import txw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_buff,
  input  logic       ev_uflo,
  output logic       wr,
  output txw_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr    <= 1'b0;
      flags <= '0;
    end else begin
      wr         <= ev_buff | ev_uflo;
      flags.buff <= ev_buff;
      flags.uflo <= ev_buff | ev_uflo;
    end
  end

endmodule

// File: rtl/txw_chain_walker.sv
module txw_chain_walker
  import txw_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txon_set,
  input  logic             tx_poll,
  output logic             txon,
  output logic             dsc_rd,
  output logic             dsc_sel,
  input  logic             dsc_ack,
  input  logic             dsc_own,
  input  logic             dsc_eop,
  input  logic [CNT_W-1:0] dsc_cnt,
  output logic             dsc_adv,
  output logic             dsc_wr,
  output logic [1:0]       dsc_wflags,
  output logic             byte_req,
  input  logic             byte_ack,
  input  logic             fifo_empty,
  input  logic             fifo_full
);

  txw_state_e st_q;
  logic       rd_q, sel_q, adv_q, chain_q, started_q, eop_q, txon_q;
  logic       xfer, cnt_last, cnt_load, ev_buff, ev_uflo;
  txw_flags_t wb_flags;

  // Byte requests only while streaming and while the FIFO has room.
  assign byte_req = (st_q == TXW_STREAM) && !fifo_full;
  assign xfer     = byte_req && byte_ack;

  // Chained fetch: unowned next entry, or FIFO dry before its status arrives.
  assign ev_buff  = (st_q == TXW_FETCH) && chain_q &&
                    (dsc_ack ? !dsc_own : fifo_empty);
  // Mid-frame starvation while streaming.
  assign ev_uflo  = (st_q == TXW_STREAM) && started_q && !xfer && fifo_empty;
  assign cnt_load = (st_q == TXW_FETCH) && dsc_ack && dsc_own;

  txw_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .inc      (xfer),
    .load_val (dsc_cnt),
    .last     (cnt_last)
  );

  txw_err_wb u_wb (
    .clk     (clk),
    .rst     (rst),
    .ev_buff (ev_buff),
    .ev_uflo (ev_uflo),
    .wr      (dsc_wr),
    .flags   (wb_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TXW_IDLE;
      rd_q      <= 1'b0;
      sel_q     <= 1'b0;
      adv_q     <= 1'b0;
      chain_q   <= 1'b0;
      started_q <= 1'b0;
      eop_q     <= 1'b0;
      txon_q    <= 1'b0;
    end else begin
      adv_q <= 1'b0;
      if (ev_buff || ev_uflo) begin
        txon_q <= 1'b0;
      end else if (txon_set) begin
        txon_q <= 1'b1;
      end

      case (st_q)
        TXW_IDLE: begin
          chain_q   <= 1'b0;
          started_q <= 1'b0;
          if (txon_q && tx_poll) begin
            st_q  <= TXW_FETCH;
            rd_q  <= 1'b1;
            sel_q <= 1'b0;
          end
        end
        TXW_FETCH: begin
          if (ev_buff) begin
            rd_q <= 1'b0;
            st_q <= TXW_IDLE;
          end else if (dsc_ack) begin
            rd_q <= 1'b0;
            if (dsc_own) begin
              eop_q <= dsc_eop;
              adv_q <= chain_q;
              st_q  <= TXW_STREAM;
            end else begin
              st_q <= TXW_IDLE;
            end
          end
        end
        TXW_STREAM: begin
          if (xfer) begin
            started_q <= 1'b1;
            if (cnt_last) begin
              if (eop_q) begin
                adv_q <= 1'b1;
                st_q  <= TXW_IDLE;
              end else begin
                // Fetch the next entry at once so its status can beat the drain.
                chain_q <= 1'b1;
                rd_q    <= 1'b1;
                sel_q   <= 1'b1;
                st_q    <= TXW_FETCH;
              end
            end
          end else if (ev_uflo) begin
            st_q <= TXW_IDLE;
          end
        end
        default: st_q <= TXW_IDLE;
      endcase
    end
  end

  assign txon       = txon_q;
  assign dsc_rd     = rd_q;
  assign dsc_sel    = sel_q;
  assign dsc_adv    = adv_q;
  assign dsc_wflags = wb_flags;

endmodule

// File: rtl/txw_chain_walker_chk.sv
module txw_chain_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       txon,
  input logic       dsc_rd,
  input logic       dsc_adv,
  input logic       dsc_wr,
  input logic [1:0] dsc_wflags,
  input logic       byte_req,
  input logic       fifo_full
);

  a_r12_buff_has_uflo: assert property (@(posedge clk) disable iff (rst)
    dsc_wr |-> dsc_wflags[0]);

  a_r7_wb_drops_txon: assert property (@(posedge clk) disable iff (rst)
    dsc_wr |-> !txon);

  a_r4_no_req_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !byte_req);

  a_r4_no_req_during_fetch: assert property (@(posedge clk) disable iff (rst)
    !(dsc_rd && byte_req));

  a_r2_fetch_needs_txon: assert property (@(posedge clk) disable iff (rst)
    $rose(dsc_rd) |-> txon);

  a_r11_adv_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dsc_adv |=> !dsc_adv);

  a_r9_quiet_after_error: assert property (@(posedge clk) disable iff (rst)
    dsc_wr |=> !byte_req);

endmodule

bind txw_chain_walker txw_chain_walker_chk u_chk (.*);

// File: tb/txw_chain_walker_tb.sv
module txw_chain_walker_tb;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic [1:0] nbuf;
    logic [7:0] l0;
    logic [7:0] l1;
    logic [7:0] l2;
    logic [3:0] own;
    logic [7:0] e_bytes;
    logic       e_wr;
    logic [1:0] e_flags;
    logic       e_txon;
    logic [1:0] e_adv;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'd1, 8'd0, 8'd0, 4'b0001, 8'd1, 1'b0, 2'd0, 1'b1, 2'd1},
    '{2'd1, 8'd5, 8'd0, 8'd0, 4'b0001, 8'd5, 1'b0, 2'd0, 1'b1, 2'd1},
    '{2'd2, 8'd3, 8'd4, 8'd0, 4'b0011, 8'd7, 1'b0, 2'd0, 1'b1, 2'd2},
    '{2'd3, 8'd2, 8'd1, 8'd6, 4'b0111, 8'd9, 1'b0, 2'd0, 1'b1, 2'd3},
    '{2'd2, 8'd4, 8'd3, 8'd0, 4'b0001, 8'd4, 1'b1, 2'd3, 1'b0, 2'd0},
    '{2'd1, 8'd5, 8'd0, 8'd0, 4'b0000, 8'd0, 1'b0, 2'd0, 1'b1, 2'd0},
    '{2'd3, 8'd1, 8'd2, 8'd3, 4'b0011, 8'd3, 1'b1, 2'd3, 1'b0, 2'd1}
  };

  logic clk, rst, txon_set, tx_poll, txon;
  logic dsc_rd, dsc_sel, dsc_ack, dsc_own, dsc_eop, dsc_adv, dsc_wr;
  logic [CNT_W-1:0] dsc_cnt;
  logic [1:0] dsc_wflags;
  logic byte_req, byte_ack, fifo_empty, fifo_full;

  int bytes, wr_n, adv_n, rd_seen, byte_lim, next_delay, watch_at;
  int checks, fails;
  logic [1:0] last_flags;
  bit armed, done;
  int d_len [8];
  bit d_own [8];
  bit d_eop [8];

  txw_chain_walker #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .txon_set(txon_set), .tx_poll(tx_poll), .txon(txon),
    .dsc_rd(dsc_rd), .dsc_sel(dsc_sel), .dsc_ack(dsc_ack), .dsc_own(dsc_own),
    .dsc_eop(dsc_eop), .dsc_cnt(dsc_cnt), .dsc_adv(dsc_adv), .dsc_wr(dsc_wr),
    .dsc_wflags(dsc_wflags), .byte_req(byte_req), .byte_ack(byte_ack),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One cycle: sample at the falling edge, then act as descriptor memory and byte source.
  task automatic step();
    int idx;
    @(negedge clk);
    if (armed) begin
      armed = 1'b0;
      chk(dsc_rd === 1'b1 && dsc_sel === 1'b1, "R5 next read right after last byte",
          int'({dsc_rd, dsc_sel}), 3);
    end
    if (dsc_adv === 1'b1) adv_n++;
    if (dsc_wr === 1'b1) begin wr_n++; last_flags = dsc_wflags; end
    if (dsc_rd === 1'b1) rd_seen++;
    if (dsc_ack) begin
      dsc_ack = 1'b0;
    end else if (dsc_rd === 1'b1) begin
      if (dsc_sel && next_delay > 0) begin
        next_delay--;
      end else begin
        idx     = (adv_n + int'(dsc_sel)) % 8;
        dsc_ack = 1'b1;
        dsc_own = d_own[idx];
        dsc_eop = d_eop[idx];
        dsc_cnt = CNT_W'(4096 - d_len[idx]);
      end
    end
    byte_ack = (byte_req === 1'b1) && (byte_lim < 0 || bytes < byte_lim);
    if (byte_ack) begin
      bytes++;
      if (bytes == watch_at) armed = 1'b1;
    end
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; txon_set = 1'b0; tx_poll = 1'b0; fifo_empty = 1'b0; fifo_full = 1'b0;
    dsc_ack = 1'b0; byte_ack = 1'b0; dsc_own = 1'b0; dsc_eop = 1'b0; dsc_cnt = '0;
    step(); step();
    rst = 1'b0;
    bytes = 0; wr_n = 0; adv_n = 0; rd_seen = 0; byte_lim = -1; next_delay = 0;
    watch_at = -1; armed = 1'b0; last_flags = 2'd0;
    for (int i = 0; i < 8; i++) begin d_len[i] = 0; d_own[i] = 1'b0; d_eop[i] = 1'b0; end
  endtask

  task automatic start();
    txon_set = 1'b1; step(); txon_set = 1'b0;
    tx_poll = 1'b1; step(); tx_poll = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;

    // Table-driven frames: R3 lengths, R5 chains, R6/R7 ownership, R11 frame end.
    for (int v = 0; v < NV; v++) begin
      do_reset();
      d_len[0] = int'(VEC[v].l0); d_len[1] = int'(VEC[v].l1); d_len[2] = int'(VEC[v].l2);
      for (int i = 0; i < 4; i++) begin
        d_own[i] = VEC[v].own[i];
        d_eop[i] = (i == int'(VEC[v].nbuf) - 1);
      end
      start();
      run(60);
      chk(bytes == int'(VEC[v].e_bytes), $sformatf("R3 byte total vec %0d", v), bytes, int'(VEC[v].e_bytes));
      chk(wr_n == int'(VEC[v].e_wr), $sformatf("R7 write-backs vec %0d", v), wr_n, int'(VEC[v].e_wr));
      chk(wr_n == 0 || last_flags == VEC[v].e_flags, $sformatf("R12 flags vec %0d", v),
          int'(last_flags), int'(VEC[v].e_flags));
      chk(txon == VEC[v].e_txon, $sformatf("R6 txon vec %0d", v), int'(txon), int'(VEC[v].e_txon));
      chk(adv_n == int'(VEC[v].e_adv), $sformatf("R11 advances vec %0d", v), adv_n, int'(VEC[v].e_adv));
    end

    // R1: reset state.
    do_reset();
    chk(txon == 1'b0 && dsc_rd == 1'b0 && byte_req == 1'b0 && dsc_wr == 1'b0 && dsc_adv == 1'b0,
        "R1 outputs low after reset", int'({txon, dsc_rd, byte_req, dsc_wr, dsc_adv}), 0);

    // R2: poll ignored while off, then turned on.
    tx_poll = 1'b1; step(); tx_poll = 1'b0;
    run(10);
    chk(rd_seen == 0, "R2 poll ignored while off", rd_seen, 0);
    txon_set = 1'b1; step(); txon_set = 1'b0;
    chk(txon == 1'b1, "R2 txon raised by set pulse", int'(txon), 1);

    // R9: starvation mid-buffer, then R2 restart only after txon_set.
    do_reset();
    d_len[0] = 6; d_own[0] = 1'b1; d_eop[0] = 1'b1;
    fifo_empty = 1'b1; byte_lim = 2;
    start();
    run(30);
    chk(bytes == 2, "R9 bytes before truncation", bytes, 2);
    chk(wr_n == 1 && last_flags == 2'b01, "R9 underflow-only write-back", int'(last_flags), 1);
    chk(txon == 1'b0, "R9 txon cleared", int'(txon), 0);
    chk(byte_req == 1'b0, "R9 no request after truncation", int'(byte_req), 0);
    rd_seen = 0; byte_lim = -1; fifo_empty = 1'b0;
    tx_poll = 1'b1; step(); tx_poll = 1'b0;
    run(10);
    chk(rd_seen == 0, "R2 poll ignored after error", rd_seen, 0);
    start();
    run(30);
    chk(bytes == 8, "R2 frame runs after txon set again", bytes, 8);

    // R8: late status of the next entry while the FIFO is dry.
    do_reset();
    d_len[0] = 3; d_own[0] = 1'b1; d_eop[0] = 1'b0;
    d_len[1] = 2; d_own[1] = 1'b1; d_eop[1] = 1'b1;
    next_delay = 4; fifo_empty = 1'b1;
    start();
    run(30);
    chk(bytes == 3, "R8 bytes of first buffer only", bytes, 3);
    chk(wr_n == 1 && last_flags == 2'b11, "R8 buffer error with underflow", int'(last_flags), 3);
    chk(txon == 1'b0, "R8 txon cleared", int'(txon), 0);
    chk(adv_n == 0, "R8 no advance", adv_n, 0);

    // R10: empty FIFO at the frame edges is harmless.
    do_reset();
    d_len[0] = 3; d_own[0] = 1'b1; d_eop[0] = 1'b1;
    fifo_empty = 1'b1;
    start();
    run(30);
    chk(wr_n == 0, "R10 no write-back", wr_n, 0);
    chk(txon == 1'b1 && bytes == 3, "R10 frame complete", bytes, 3);

    // R4: full FIFO holds requests.
    do_reset();
    d_len[0] = 4; d_own[0] = 1'b1; d_eop[0] = 1'b1;
    fifo_full = 1'b1;
    start();
    run(6);
    chk(byte_req == 1'b0 && bytes == 0, "R4 no request while full", bytes, 0);
    fifo_full = 1'b0;
    run(20);
    chk(bytes == 4 && adv_n == 1, "R4 resumes after full clears", bytes, 4);

    // R5: next-entry read immediately after last byte of a chained buffer.
    do_reset();
    d_len[0] = 2; d_own[0] = 1'b1; d_eop[0] = 1'b0;
    d_len[1] = 3; d_own[1] = 1'b1; d_eop[1] = 1'b1;
    watch_at = 2;
    start();
    run(30);
    chk(bytes == 5 && adv_n == 2, "R5 chained frame total", bytes, 5);

    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule